// File: doc/BRIEF.md
# Word-Length-Aware Special Character Detector

This block sits between a serial receiver and its receive FIFO. It checks every received character against a special character value held in a configuration register. When detection is switched on and a character matches, the block raises a one-clock detect pulse and sets a sticky status bit, which also drives an interrupt request. The matching character is not removed from the data stream: like every other character, it goes on to the FIFO write port.

The comparison uses only as many low-order bits as the configured word length allows, which is 5, 6, 7 or 8. Bit 0 of the special character register lines up with the first received bit, which is the least significant bit of the character. Bits above the word length are forced to zero on both operands, so they cannot affect a match. Software clears the status bit by reading the interrupt status, which the block sees as a one-clock read strobe.

Top module: `spchar_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, `fifo_wr`, `fifo_data`, `det_pulse`, `det_status` and `irq` all become zero.
- R2: Each cycle with `rx_valid` high produces `fifo_wr` high on the next cycle, with `fifo_data` equal to the unmodified `rx_data`. This holds whether or not the character matched.
- R3: `word_len` selects how many low bits are compared: 2'b00 compares bits 4:0, 2'b01 compares bits 5:0, 2'b10 compares bits 6:0 and 2'b11 compares bits 7:0. Bits above the selected width are ignored in both `rx_data` and `spec_char`.
- R4: While `det_en` is low, a received character causes neither `det_pulse` nor a set of `det_status`.
- R5: For each valid, enabled, matching character, `det_pulse` is high for exactly the one cycle in which its `fifo_wr` is high.
- R6: Once set, `det_status` stays high until the cycle after `isr_read` is sampled high. It is then cleared, unless a new match arrives in that same cycle.
- R7: When a match and `isr_read` fall in the same cycle, `det_status` is high on the next cycle.
- R8: `irq` always equals `det_status`.
- R9: A cycle with `rx_valid` low produces `fifo_wr` low and `det_pulse` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Received character, bit 0 first received |
| rx_valid | input | 1 | One-cycle strobe marking `rx_data` valid |
| word_len | input | 2 | Word length code, 5 to 8 bits |
| det_en | input | 1 | Special character detection enable |
| spec_char | input | 8 | Programmed special character |
| isr_read | input | 1 | Interrupt status read strobe, clears the status |
| fifo_data | output | 8 | Character forwarded to the FIFO |
| fifo_wr | output | 1 | FIFO write strobe |
| det_pulse | output | 1 | One-cycle match indication |
| det_status | output | 1 | Sticky special character status |
| irq | output | 1 | Interrupt request |

## Verification
The setting of the status bit by a new match and its clearing by a status read can happen in the same cycle. The bench provokes this both in a directed case and through random read strobes that overlap random matching characters. A bench model in which setting has priority over clearing predicts the expected status, and every cycle the bench compares `det_status` and `irq` with that prediction. Matches are made likely by building characters from the special character with random upper bits, which also exercises the masking at all four word lengths.

// File: rtl/spchar_pkg.sv
// Package: shared constants and the word length code type for the
// special character detector. Assumes a 2-bit word length code.
package spchar_pkg;
    localparam int CHAR_W   = 8;
    localparam int MIN_BITS = 5;
    localparam int WLEN_W   = 2;

    typedef enum logic [WLEN_W-1:0] {
        WLEN_5 = 2'b00,
        WLEN_6 = 2'b01,
        WLEN_7 = 2'b10,
        WLEN_8 = 2'b11
    } wlen_e;
endpackage

// File: rtl/spchar_mask.sv
// Module: builds the compare mask from the word length code.
// Bit i of the mask is set when i < MIN_BITS + code. Purely combinational.
module spchar_mask #(
    parameter int CHAR_W   = 8,
    parameter int MIN_BITS = 5,
    parameter int WLEN_W   = 2
) (
    input  logic [WLEN_W-1:0] wlen,
    output logic [CHAR_W-1:0] mask
);
    localparam int FIXED = (MIN_BITS < CHAR_W) ? MIN_BITS : CHAR_W;

    // one mask bit per character bit; low bits are always compared
    for (genvar g = 0; g < CHAR_W; g++) begin : g_bit
        if (g < FIXED) begin : g_fixed
            assign mask[g] = 1'b1;
        end else begin : g_var
            assign mask[g] = (int'(wlen) > (g - MIN_BITS));
        end
    end
endmodule

// File: rtl/spchar_cmp.sv
// Module: masks both operands and compares them; qualifies the hit with
// the valid strobe and the enable. Assumes mask is already width-aligned.
module spchar_cmp #(
    parameter int CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] rx_char,
    input  logic [CHAR_W-1:0] ref_char,
    input  logic [CHAR_W-1:0] mask,
    input  logic              valid,
    input  logic              enable,
    output logic              hit
);
    logic [CHAR_W-1:0] rx_m;
    logic [CHAR_W-1:0] ref_m;

    // force bits above the word length to zero on both sides, then compare
    always_comb begin
        rx_m  = rx_char & mask;
        ref_m = ref_char & mask;
        hit   = valid && enable && (rx_m == ref_m);
    end
endmodule

// File: rtl/spchar_flag.sv
// Module: sticky status flag. A set wins over a clear in the same cycle.
// Assumes a synchronous active-low reset.
module spchar_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // hold the flag until cleared; a set in the same cycle keeps it high
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set)     flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);                                   // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);                                              // R7
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);                                   // R6
endmodule

// File: rtl/spchar_detect.sv
// Module: top of the special character detector. Registers the character
// to the FIFO write port and flags matches with a one-cycle pulse plus a
// sticky status. Assumes rx_valid is a one-cycle strobe per character.
module spchar_detect
    import spchar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic [WLEN_W-1:0] word_len,
    input  logic              det_en,
    input  logic [CHAR_W-1:0] spec_char,
    input  logic              isr_read,
    output logic [CHAR_W-1:0] fifo_data,
    output logic              fifo_wr,
    output logic              det_pulse,
    output logic              det_status,
    output logic              irq
);
    logic [CHAR_W-1:0] cmp_mask;
    logic              hit;

    spchar_mask #(.CHAR_W(CHAR_W), .MIN_BITS(MIN_BITS), .WLEN_W(WLEN_W)) u_mask (
        .wlen (word_len),
        .mask (cmp_mask)
    );

    spchar_cmp #(.CHAR_W(CHAR_W)) u_cmp (
        .rx_char  (rx_data),
        .ref_char (spec_char),
        .mask     (cmp_mask),
        .valid    (rx_valid),
        .enable   (det_en),
        .hit      (hit)
    );

    spchar_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (hit),
        .clr   (isr_read),
        .flag  (det_status)
    );

    // forward every character unchanged, with the detect pulse aligned
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_data <= '0;
            fifo_wr   <= 1'b0;
            det_pulse <= 1'b0;
        end else begin
            fifo_wr   <= rx_valid;
            det_pulse <= hit;
            if (rx_valid) fifo_data <= rx_data;
        end
    end

    // the interrupt request mirrors the sticky status
    assign irq = det_status;

    AST_WR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (fifo_wr && fifo_data == $past(rx_data)));     // R2
    AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> (!fifo_wr && !det_pulse));                    // R9
    AST_PULSE_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> fifo_wr);                                     // R5
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> !det_pulse);                                    // R4
    AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> det_status);                                  // R5
endmodule

// File: tb/spchar_detect_test.sv
module spchar_detect_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic [1:0] word_len;
    logic       det_en;
    logic [7:0] spec_char;
    logic       isr_read;
    logic [7:0] fifo_data;
    logic       fifo_wr, det_pulse, det_status, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    logic [7:0] m_data;
    logic       m_wr, m_pulse, m_status;

    spchar_detect uut (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .word_len(word_len), .det_en(det_en), .spec_char(spec_char),
        .isr_read(isr_read), .fifo_data(fifo_data), .fifo_wr(fifo_wr),
        .det_pulse(det_pulse), .det_status(det_status), .irq(irq)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [7:0] width_mask(input logic [1:0] wl);
        return 8'((9'd1 << (5 + int'(wl))) - 9'd1);
    endfunction

    function automatic logic is_match(input logic [7:0] a, input logic [7:0] b,
                                      input logic [1:0] wl);
        return ((a & width_mask(wl)) == (b & width_mask(wl)));
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // apply one cycle of inputs, advance the model, check after the edge
    task automatic step(input logic v, input logic [7:0] d, input logic rd);
        logic hit;
        rx_valid = v; rx_data = d; isr_read = rd;
        hit = v && det_en && is_match(d, spec_char, word_len);
        m_wr    = v;
        m_pulse = hit;
        if (v) m_data = d;
        if (hit) m_status = 1'b1;
        else if (rd) m_status = 1'b0;
        @(posedge clk); #2;
        chk(v ? "R2" : "R9", "fifo_wr", {7'd0, fifo_wr}, {7'd0, m_wr});
        if (v) chk("R2", "fifo_data", fifo_data, m_data);
        chk(det_en ? "R5" : "R4", "det_pulse", {7'd0, det_pulse}, {7'd0, m_pulse});
        chk("R6", "det_status", {7'd0, det_status}, {7'd0, m_status});
        chk("R8", "irq", {7'd0, irq}, {7'd0, m_status});
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; rx_valid = 0; rx_data = 8'hFF; isr_read = 0;
        word_len = 2'b11; det_en = 1'b1; spec_char = 8'h00;
        m_data = '0; m_wr = 0; m_pulse = 0; m_status = 0;
        @(posedge clk); #2;
        rx_valid = 1; rx_data = 8'h00;   // matching input held during reset
        @(posedge clk); #2;
        // R1: reset state
        chk("R1", "fifo_wr", {7'd0, fifo_wr}, 8'd0);
        chk("R1", "fifo_data", fifo_data, 8'd0);
        chk("R1", "det_pulse", {7'd0, det_pulse}, 8'd0);
        chk("R1", "det_status", {7'd0, det_status}, 8'd0);
        chk("R1", "irq", {7'd0, irq}, 8'd0);
        rst_n = 1'b1; rx_valid = 0;

        // R3: 5-bit word length, upper bits differ but still match
        word_len = 2'b00; spec_char = 8'h13;
        step(1, 8'hF3, 0);
        chk("R3", "5-bit match status", {7'd0, det_status}, 8'd1);
        step(0, 8'h00, 1);                 // clear via read (R6)
        step(1, 8'h12, 0);                 // low-bit mismatch
        chk("R3", "5-bit mismatch pulse", {7'd0, det_pulse}, 8'd0);
        // R3: 8-bit word length, bit 7 differs -> no match
        word_len = 2'b11; spec_char = 8'h41;
        step(1, 8'hC1, 0);
        chk("R3", "8-bit bit7 mismatch", {7'd0, det_pulse}, 8'd0);
        // R3: 7-bit word length ignores bit 7
        word_len = 2'b10;
        step(1, 8'hC1, 0);
        chk("R3", "7-bit match", {7'd0, det_pulse}, 8'd1);
        // R7: match and read in the same cycle
        step(1, 8'h41, 1);
        chk("R7", "set wins over read", {7'd0, det_status}, 8'd1);
        step(0, 8'h00, 0);
        chk("R6", "status held", {7'd0, det_status}, 8'd1);
        step(0, 8'h00, 1);
        // R4: disabled
        det_en = 0;
        step(1, 8'h41, 0);
        chk("R4", "disabled no status", {7'd0, det_status}, 8'd0);
        det_en = 1;

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] d;
            if (($urandom % 8) == 0) begin
                word_len  = 2'($urandom);
                spec_char = 8'($urandom);
                det_en    = (($urandom % 5) != 0);
            end
            if (($urandom % 2) == 0)
                d = (spec_char & width_mask(word_len)) | (8'($urandom) & ~width_mask(word_len));
            else
                d = 8'($urandom);
            step(($urandom % 3) != 0, d, ($urandom % 5) == 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule